// File: doc/BRIEF.md
# Cache miss tracking entry

This block tracks a single outstanding block miss in a non-blocking cache that snoops a shared bus. When a miss is allocated, the entry stores the block address, the access size, an order tag, an uncacheable flag and a simple-forward flag. It then collects the requesters waiting for that block in two bounded queues.

The primary queue holds targets that the current memory request will satisfy. The deferred queue holds targets that need a second request. Targets go to the deferred queue when they arrive after the request was issued and cannot be served by it. The entry watches snoops and fill responses. It rewrites upgrade requests into read-exclusive requests, records conflicting snoops as memory-side targets and answers each snoop. It also merges or promotes the deferred queue when the coherence outcome allows.

One operation is presented per cycle on `op_valid`/`op_kind`. Snoop and fill answers and popped targets appear combinationally in the same cycle. State changes at the next rising clock edge. Illegal operations change nothing and set a sticky protocol-error output.

Top module: `miss_entry`

## Requirements
- R1: Operation codes are ALLOC=0, ADD=1, SERVICE=2, SNOOP=3, FILL=4, POP=5, PROMOTE=6, DEALLOC=7, DN_SET=8, DN_CLR=9. Request codes are READ=0, READ_EX=1, UPGRADE=2. ALLOC on an idle entry does the following: it stores the address, size, order tag, uncacheable flag and simple-forward flag. It places the request in the primary queue as a CPU-side, marked target. It clears in-service, downstream-pending, pending-invalidate and pending-shared.
- R2: Each queue has a needs-exclusive flag and a has-upgrade flag. They are set only when a CPU-side target is added whose code is READ_EX or UPGRADE (needs-exclusive) or UPGRADE (has-upgrade). The primary queue's flags are output as `need_excl` and `upg_pending`.
- R3: ADD places the target in the deferred queue when the entry is in service and any one of these holds: the deferred queue is non-empty, pending-invalidate is set, or the primary queue is not exclusive while the new code is READ_EX or UPGRADE. Otherwise ADD places it in the primary queue. A target added to the primary queue is marked only if the entry is not yet in service.
- R4: A snoop leaves the entry unchanged and gets no answer in two cases: the entry is not in service, or the snoop is express while downstream-pending is set. The exception is an exclusive snoop in these cases, which rewrites every UPGRADE target in both queues to READ_EX.
- R5: When the entry is in service, an exclusive snoop rewrites UPGRADE targets in the deferred queue only. If pending-invalidate is already set, the snoop is acknowledged (`snp_hit`=1) and nothing else changes.
- R6: Consider an in-service snoop while pending-invalidate is clear, where the primary queue or the snoop is exclusive. The snoop is appended to the primary queue as a memory-side target, with code READ_EX if exclusive and READ otherwise. If the primary queue is exclusive, `snp_inhibit` and `snp_supply_excl` are asserted. An exclusive snoop sets pending-invalidate.
- R7: An in-service read snoop that meets a non-exclusive primary queue, with pending-invalidate clear, records no target. It asserts `snp_shared` and sets pending-shared.
- R8: FILL drives `fill_shared_out` = `fill_shared` OR pending-shared. If that result is 0, pending-invalidate is clear and the deferred queue is exclusive, the following happens: the primary queue becomes exclusive, and the whole deferred queue is appended to the primary tail with its marks cleared.
- R9: PROMOTE is legal only when the primary queue is empty and the deferred queue is not. It moves the deferred queue and its flags into the primary queue. It clears pending-invalidate, pending-shared and in-service, and loads the order tag from the new head.
- R10: SERVICE on a simple-forward entry must find exactly one target. It pops that target and asserts `retired`. Otherwise SERVICE sets in-service, and clears every primary mark when downstream-pending is clear.
- R11: Each queue holds DEPTH targets and reports full. An add that would overflow a queue is dropped and sets the protocol error.
- R12: DEALLOC is legal only with both queues empty. `proto_err` is sticky and is set by any illegal operation: a bad DEALLOC, ALLOC while busy, other operations while idle, SERVICE while in service, POP of an empty queue, or an illegal PROMOTE.
- R13: POP removes the primary head in FIFO order. It shows the head's code, CPU-side flag, mark and order tag on the pop outputs with `pop_valid`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation strobe |
| op_kind | input | 4 | Operation code |
| in_addr | input | ADDR_W | Block address for ALLOC |
| in_size | input | SIZE_W | Access size for ALLOC |
| in_order | input | 8 | Order tag of the request or snoop |
| in_cmd | input | 2 | Request code for ALLOC/ADD |
| in_uncache | input | 1 | Uncacheable flag for ALLOC |
| in_simple_fwd | input | 1 | Simple-forward flag for ALLOC |
| snp_excl | input | 1 | Snoop needs exclusive access |
| snp_express | input | 1 | Snoop is express |
| fill_shared | input | 1 | Fill response arrived shared |
| entry_valid | output | 1 | Entry is allocated |
| entry_addr | output | ADDR_W | Stored address |
| entry_size | output | SIZE_W | Stored size |
| entry_order | output | 8 | Stored order tag |
| entry_uncache | output | 1 | Stored uncacheable flag |
| in_service | output | 1 | Request issued to memory |
| need_excl | output | 1 | Primary queue needs exclusive |
| upg_pending | output | 1 | Primary queue holds an upgrade |
| pend_inval | output | 1 | Pending invalidate |
| pend_shared | output | 1 | Pending shared |
| dn_pending | output | 1 | Downstream pending |
| snp_hit | output | 1 | Snoop acts on this entry |
| snp_inhibit | output | 1 | Inhibit memory response |
| snp_supply_excl | output | 1 | This entry will supply an exclusive copy |
| snp_shared | output | 1 | Assert shared line on snoop |
| fill_shared_out | output | 1 | Shared indication on the fill |
| retired | output | 1 | Simple-forward target retired |
| pop_valid | output | 1 | A target is removed this cycle |
| pop_cmd | output | 2 | Removed target code |
| pop_cpu | output | 1 | Removed target is CPU-side |
| pop_mark | output | 1 | Removed target is marked |
| pop_order | output | 8 | Removed target order tag |
| prim_cnt | output | CW | Primary queue occupancy |
| def_cnt | output | CW | Deferred queue occupancy |
| prim_full | output | 1 | Primary queue full |
| def_full | output | 1 | Deferred queue full |
| proto_err | output | 1 | Sticky protocol error |

## Verification
Target placement is tried in four cases, each separating the primary and deferred decisions:
- targets added before issue;
- a read-exclusive added after a non-exclusive issue;
- a follower behind an occupied deferred queue;
- targets added behind a pending invalidate.

Snoops come in read and exclusive forms against exclusive and shared requests, both idle and in service, and express snoops arrive with downstream-pending set. These cases separate a recorded snoop, a shared answer, an acknowledged-only snoop and an ignored snoop, and show which queue's upgrades are rewritten. Fills arrive shared, unshared and under pending-shared, which separates merging from deferral. Promotion, simple forwarding, a full queue and an early deallocate cover the list moves and the error paths.

// File: rtl/miss_pkg.sv
package miss_pkg;
   localparam int ORD_W = 8;

   typedef enum logic [1:0] {
      CMD_READ    = 2'd0,
      CMD_READ_EX = 2'd1,
      CMD_UPGRADE = 2'd2
   } cmd_e;

   typedef enum logic [3:0] {
      OP_ALLOC   = 4'd0,
      OP_ADD     = 4'd1,
      OP_SERVICE = 4'd2,
      OP_SNOOP   = 4'd3,
      OP_FILL    = 4'd4,
      OP_POP     = 4'd5,
      OP_PROMOTE = 4'd6,
      OP_DEALLOC = 4'd7,
      OP_DN_SET  = 4'd8,
      OP_DN_CLR  = 4'd9
   } op_e;

   typedef struct packed {
      logic             cpu;
      logic             mark;
      cmd_e             cmd;
      logic [ORD_W-1:0] ord;
   } tgt_t;
endpackage

// File: rtl/miss_tgt_list.sv
module miss_tgt_list
   import miss_pkg::*;
#(
   parameter  int DEPTH = 8,
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clear,
   input  logic                push,
   input  tgt_t                push_d,
   input  logic                pop,
   input  logic                merge,
   input  logic                replace,
   input  tgt_t [DEPTH-1:0]    merge_d,
   input  logic [CW-1:0]       merge_cnt,
   input  logic                merge_excl,
   input  logic                merge_upg,
   input  logic                fix_upg,
   input  logic                clr_marks,
   output tgt_t [DEPTH-1:0]    items,
   output logic [CW-1:0]       cnt,
   output logic                empty,
   output logic                full,
   output logic                needs_excl,
   output logic                has_upg
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("miss_tgt_list: DEPTH must be at least 2");
   end

   tgt_t [DEPTH-1:0] items_q, adj, nxt;
   logic [CW-1:0]    cnt_q, ncnt;
   logic             ne_q, hu_q, nne, nhu;

   // per-slot rewrite of upgrades and marks
   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      assign adj[g] = '{cpu:  items_q[g].cpu,
                        mark: items_q[g].mark & ~clr_marks,
                        cmd:  (fix_upg && items_q[g].cmd == CMD_UPGRADE) ? CMD_READ_EX : items_q[g].cmd,
                        ord:  items_q[g].ord};
   end

   always_comb begin
      nxt  = adj;
      ncnt = cnt_q;
      nne  = ne_q;
      nhu  = hu_q & ~fix_upg;
      if (pop && cnt_q != '0) begin
         for (int i = 0; i < DEPTH - 1; i++) nxt[i] = adj[i+1];
         ncnt = cnt_q - CW'(1);
      end
      if (push && ncnt != CW'(DEPTH)) begin
         for (int i = 0; i < DEPTH; i++)
            if (CW'(i) == ncnt) nxt[i] = push_d;
         ncnt = ncnt + CW'(1);
         if (push_d.cpu && push_d.cmd != CMD_READ)    nne = 1'b1;
         if (push_d.cpu && push_d.cmd == CMD_UPGRADE) nhu = 1'b1;
      end
      if (merge) begin
         for (int j = 0; j < DEPTH; j++)
            for (int i = 0; i < DEPTH; i++)
               if (CW'(j) < merge_cnt && CW'(i) == cnt_q + CW'(j)) nxt[i] = merge_d[j];
         ncnt = cnt_q + merge_cnt;
         nne  = (ne_q & ~replace) | merge_excl;
         nhu  = (hu_q & ~replace) | merge_upg;
      end
      if (clear) begin
         ncnt = '0;
         nne  = 1'b0;
         nhu  = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         items_q <= '0;
         cnt_q   <= '0;
         ne_q    <= 1'b0;
         hu_q    <= 1'b0;
      end else begin
         items_q <= nxt;
         cnt_q   <= ncnt;
         ne_q    <= nne;
         hu_q    <= nhu;
      end
   end

   assign items      = items_q;
   assign cnt        = cnt_q;
   assign empty      = (cnt_q == '0);
   assign full       = (cnt_q == CW'(DEPTH));
   assign needs_excl = ne_q;
   assign has_upg    = hu_q;

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) cnt_q <= CW'(DEPTH)); // R11
   AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push && !merge && !clear && cnt_q != '0) |=> cnt_q == $past(cnt_q) - CW'(1)); // R13
endmodule

// File: rtl/miss_entry.sv
module miss_entry
   import miss_pkg::*;
#(
   parameter  int ADDR_W = 32,
   parameter  int SIZE_W = 7,
   parameter  int DEPTH  = 8,
   localparam int CW     = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [3:0]        op_kind,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic [SIZE_W-1:0] in_size,
   input  logic [ORD_W-1:0]  in_order,
   input  logic [1:0]        in_cmd,
   input  logic              in_uncache,
   input  logic              in_simple_fwd,
   input  logic              snp_excl,
   input  logic              snp_express,
   input  logic              fill_shared,
   output logic              entry_valid,
   output logic [ADDR_W-1:0] entry_addr,
   output logic [SIZE_W-1:0] entry_size,
   output logic [ORD_W-1:0]  entry_order,
   output logic              entry_uncache,
   output logic              in_service,
   output logic              need_excl,
   output logic              upg_pending,
   output logic              pend_inval,
   output logic              pend_shared,
   output logic              dn_pending,
   output logic              snp_hit,
   output logic              snp_inhibit,
   output logic              snp_supply_excl,
   output logic              snp_shared,
   output logic              fill_shared_out,
   output logic              retired,
   output logic              pop_valid,
   output logic [1:0]        pop_cmd,
   output logic              pop_cpu,
   output logic              pop_mark,
   output logic [ORD_W-1:0]  pop_order,
   output logic [CW-1:0]     prim_cnt,
   output logic [CW-1:0]     def_cnt,
   output logic              prim_full,
   output logic              def_full,
   output logic              proto_err
);
   if (ADDR_W < 1 || SIZE_W < 1) begin : g_bad_width
      $error("miss_entry: ADDR_W and SIZE_W must be positive");
   end

   // entry state
   logic              valid_q, svc_q, dn_q, pinv_q, pshr_q, sfwd_q, unc_q, err_q;
   logic [ADDR_W-1:0] addr_q;
   logic [SIZE_W-1:0] size_q;
   logic [ORD_W-1:0]  ord_q;

   // queue wiring
   tgt_t [DEPTH-1:0] p_items, d_items, m_data;
   logic [CW-1:0]    p_cnt, d_cnt;
   logic p_empty, p_full, p_ne, p_hu, d_empty, d_full, d_ne, d_hu;
   logic p_push, p_pop, p_merge, p_clear, p_fix, p_clr, d_push, d_clear, d_fix;
   tgt_t p_push_d, d_push_d;

   op_e  kind;
   logic go_alloc, go_add, go_svc, go_snp, go_fill, go_pop, go_prom, go_deal, go_dset, go_dclr;
   logic new_excl, add_to_def, hit_c, act_c, rec_c, fshr_any, fill_merge, fits, err_now;
   logic a_alloc, a_add, a_svc, a_snp, a_prom, a_deal, a_merge, a_pop;

   assign kind     = op_e'(op_kind);
   assign go_alloc = op_valid && kind == OP_ALLOC;
   assign go_add   = op_valid && kind == OP_ADD;
   assign go_svc   = op_valid && kind == OP_SERVICE;
   assign go_snp   = op_valid && kind == OP_SNOOP;
   assign go_fill  = op_valid && kind == OP_FILL;
   assign go_pop   = op_valid && kind == OP_POP;
   assign go_prom  = op_valid && kind == OP_PROMOTE;
   assign go_deal  = op_valid && kind == OP_DEALLOC;
   assign go_dset  = op_valid && kind == OP_DN_SET;
   assign go_dclr  = op_valid && kind == OP_DN_CLR;

   // placement and snoop decisions
   assign new_excl   = cmd_e'(in_cmd) != CMD_READ;
   assign add_to_def = svc_q && (!d_empty || pinv_q || (!p_ne && new_excl));
   assign hit_c      = valid_q && svc_q && !(snp_express && dn_q);
   assign act_c      = hit_c && !pinv_q;
   assign rec_c      = act_c && (p_ne || snp_excl);
   assign fshr_any   = fill_shared || pshr_q;
   assign fill_merge = go_fill && valid_q && !fshr_any && !pinv_q && d_ne && !d_empty;
   assign fits       = ({1'b0, p_cnt} + {1'b0, d_cnt}) <= (CW+1)'(DEPTH);

   always_comb begin
      err_now = 1'b0;
      if (go_alloc && valid_q) err_now = 1'b1;
      if ((go_add || go_svc || go_fill || go_pop || go_prom || go_deal || go_dset || go_dclr) && !valid_q)
         err_now = 1'b1;
      if (go_add && valid_q && (add_to_def ? d_full : p_full)) err_now = 1'b1;
      if (go_svc && valid_q && svc_q) err_now = 1'b1;
      if (go_svc && valid_q && sfwd_q && !(p_cnt == CW'(1) && d_empty)) err_now = 1'b1;
      if (go_pop && p_empty) err_now = 1'b1;
      if (go_prom && !(p_empty && !d_empty)) err_now = 1'b1;
      if (go_deal && !(p_empty && d_empty)) err_now = 1'b1;
      if (go_snp && rec_c && p_full) err_now = 1'b1;
      if (fill_merge && !fits) err_now = 1'b1;
   end

   assign a_alloc = go_alloc && !err_now;
   assign a_add   = go_add   && !err_now;
   assign a_svc   = go_svc   && !err_now;
   assign a_snp   = go_snp   && !err_now;
   assign a_prom  = go_prom  && !err_now;
   assign a_deal  = go_deal  && !err_now;
   assign a_pop   = go_pop   && !err_now;
   assign a_merge = fill_merge && !err_now;

   // target records for the two queues
   always_comb begin
      p_push_d = '{cpu: 1'b1, mark: 1'b1, cmd: cmd_e'(in_cmd), ord: in_order};
      if (a_add) p_push_d.mark = !svc_q;
      if (a_snp) p_push_d = '{cpu: 1'b0, mark: dn_q && p_ne,
                              cmd: snp_excl ? CMD_READ_EX : CMD_READ, ord: in_order};
   end
   assign d_push_d = '{cpu: 1'b1, mark: 1'b1, cmd: cmd_e'(in_cmd), ord: in_order};

   assign p_push  = a_alloc || (a_add && !add_to_def) || (a_snp && rec_c);
   assign p_pop   = a_pop || (a_svc && sfwd_q);
   assign p_merge = a_merge || a_prom;
   assign p_clear = a_deal;
   assign p_fix   = go_snp && valid_q && snp_excl && !hit_c;
   assign p_clr   = a_svc && !sfwd_q && !dn_q;
   assign d_push  = a_add && add_to_def;
   assign d_clear = a_deal || p_merge;
   assign d_fix   = go_snp && valid_q && snp_excl;

   // marks survive promotion, are dropped when merged by a fill
   for (genvar g = 0; g < DEPTH; g++) begin : g_mrg
      assign m_data[g] = '{cpu: d_items[g].cpu, mark: a_prom & d_items[g].mark,
                           cmd: d_items[g].cmd, ord: d_items[g].ord};
   end

   miss_tgt_list #(.DEPTH(DEPTH)) u_prim (
      .clk(clk), .rst_n(rst_n), .clear(p_clear), .push(p_push), .push_d(p_push_d),
      .pop(p_pop), .merge(p_merge), .replace(a_prom), .merge_d(m_data), .merge_cnt(d_cnt),
      .merge_excl(a_prom ? d_ne : 1'b1), .merge_upg(d_hu), .fix_upg(p_fix), .clr_marks(p_clr),
      .items(p_items), .cnt(p_cnt), .empty(p_empty), .full(p_full),
      .needs_excl(p_ne), .has_upg(p_hu));

   miss_tgt_list #(.DEPTH(DEPTH)) u_defer (
      .clk(clk), .rst_n(rst_n), .clear(d_clear), .push(d_push), .push_d(d_push_d),
      .pop(1'b0), .merge(1'b0), .replace(1'b0), .merge_d(p_items), .merge_cnt(p_cnt),
      .merge_excl(1'b0), .merge_upg(1'b0), .fix_upg(d_fix), .clr_marks(1'b0),
      .items(d_items), .cnt(d_cnt), .empty(d_empty), .full(d_full),
      .needs_excl(d_ne), .has_upg(d_hu));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0; svc_q <= 1'b0; dn_q <= 1'b0; pinv_q <= 1'b0; pshr_q <= 1'b0;
         sfwd_q  <= 1'b0; unc_q <= 1'b0; err_q <= 1'b0;
         addr_q  <= '0;   size_q <= '0;  ord_q <= '0;
      end else begin
         err_q <= err_q | err_now;
         if (a_alloc) begin
            valid_q <= 1'b1; addr_q <= in_addr; size_q <= in_size; ord_q <= in_order;
            unc_q <= in_uncache; sfwd_q <= in_simple_fwd;
            svc_q <= 1'b0; dn_q <= 1'b0; pinv_q <= 1'b0; pshr_q <= 1'b0;
         end
         if (a_svc && !sfwd_q) svc_q <= 1'b1;
         if (a_snp && act_c && snp_excl) pinv_q <= 1'b1;
         if (a_snp && act_c && !p_ne && !snp_excl) pshr_q <= 1'b1;
         if (a_prom) begin
            pinv_q <= 1'b0; pshr_q <= 1'b0; svc_q <= 1'b0; ord_q <= d_items[0].ord;
         end
         if (go_dset && valid_q) dn_q <= 1'b1;
         if (go_dclr && valid_q) dn_q <= 1'b0;
         if (a_deal) begin
            valid_q <= 1'b0; svc_q <= 1'b0; dn_q <= 1'b0; pinv_q <= 1'b0; pshr_q <= 1'b0;
         end
      end
   end

   assign entry_valid     = valid_q;
   assign entry_addr      = addr_q;
   assign entry_size      = size_q;
   assign entry_order     = ord_q;
   assign entry_uncache   = unc_q;
   assign in_service      = svc_q;
   assign need_excl       = p_ne;
   assign upg_pending     = p_hu;
   assign pend_inval      = pinv_q;
   assign pend_shared     = pshr_q;
   assign dn_pending      = dn_q;
   assign snp_hit         = a_snp && hit_c;
   assign snp_inhibit     = a_snp && act_c && p_ne;
   assign snp_supply_excl = a_snp && act_c && p_ne;
   assign snp_shared      = a_snp && act_c && !p_ne && !snp_excl;
   assign fill_shared_out = go_fill && fshr_any;
   assign retired         = a_svc && sfwd_q;
   assign pop_valid       = p_pop;
   assign pop_cmd         = p_items[0].cmd;
   assign pop_cpu         = p_items[0].cpu;
   assign pop_mark        = p_items[0].mark;
   assign pop_order       = p_items[0].ord;
   assign prim_cnt        = p_cnt;
   assign def_cnt         = d_cnt;
   assign prim_full       = p_full;
   assign def_full        = d_full;
   assign proto_err       = err_q;

   AST_DEFER_NEEDS_SVC: assert property (@(posedge clk) disable iff (!rst_n) !d_empty |-> svc_q); // R3
   AST_INHIBIT_IN_SVC: assert property (@(posedge clk) disable iff (!rst_n) snp_inhibit |-> svc_q); // R6
   AST_SHARED_NOT_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n) !(snp_shared && snp_inhibit)); // R7
   AST_PROMOTE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      a_prom |=> (!pinv_q && !pshr_q && !svc_q)); // R9
   AST_SVC_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (go_svc && valid_q && !svc_q && !sfwd_q) |=> svc_q); // R10
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) err_q |=> err_q); // R12
endmodule

// File: tb/tb_miss_entry.sv
module tb_miss_entry;
   localparam int K_ALLOC = 0, K_ADD = 1, K_SVC = 2, K_SNP = 3, K_FILL = 4,
                  K_POP = 5, K_PROM = 6, K_DEAL = 7, K_DSET = 8;
   localparam int C_RD = 0, C_RX = 1, C_UP = 2;

   logic clk = 1'b0, rst_n = 1'b0;
   logic op_valid = 1'b0;
   logic [3:0] op_kind = '0;
   logic [31:0] in_addr = 32'h1000;
   logic [6:0] in_size = 7'd64;
   logic [7:0] in_order = '0;
   logic [1:0] in_cmd = '0;
   logic in_uncache = 1'b0, in_simple_fwd = 1'b0, snp_excl = 1'b0, snp_express = 1'b0, fill_shared = 1'b0;
   logic entry_valid, entry_uncache, in_service, need_excl, upg_pending, pend_inval, pend_shared, dn_pending;
   logic [31:0] entry_addr;
   logic [6:0] entry_size;
   logic [7:0] entry_order, pop_order;
   logic snp_hit, snp_inhibit, snp_supply_excl, snp_shared, fill_shared_out, retired;
   logic pop_valid, pop_cpu, pop_mark, prim_full, def_full, proto_err;
   logic [1:0] pop_cmd;
   logic [3:0] prim_cnt, def_cnt;

   int n_chk = 0, n_err = 0;
   int r_hit, r_inh, r_sup, r_shr, r_fsh, r_ret, r_pv, r_pcmd, r_pcpu, r_pmark, r_pord;

   miss_entry dut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind), .in_addr(in_addr),
      .in_size(in_size), .in_order(in_order), .in_cmd(in_cmd), .in_uncache(in_uncache),
      .in_simple_fwd(in_simple_fwd), .snp_excl(snp_excl), .snp_express(snp_express),
      .fill_shared(fill_shared), .entry_valid(entry_valid), .entry_addr(entry_addr),
      .entry_size(entry_size), .entry_order(entry_order), .entry_uncache(entry_uncache),
      .in_service(in_service), .need_excl(need_excl), .upg_pending(upg_pending),
      .pend_inval(pend_inval), .pend_shared(pend_shared), .dn_pending(dn_pending),
      .snp_hit(snp_hit), .snp_inhibit(snp_inhibit), .snp_supply_excl(snp_supply_excl),
      .snp_shared(snp_shared), .fill_shared_out(fill_shared_out), .retired(retired),
      .pop_valid(pop_valid), .pop_cmd(pop_cmd), .pop_cpu(pop_cpu), .pop_mark(pop_mark),
      .pop_order(pop_order), .prim_cnt(prim_cnt), .def_cnt(def_cnt), .prim_full(prim_full),
      .def_full(def_full), .proto_err(proto_err));

   always #4 clk = ~clk;

   task automatic chk(input string tag, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_err++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   // drive at a falling edge, capture combinational answers, let one rising edge pass
   task automatic do_op(input int k, input int cmd = 0, input int ord = 0, input bit sf = 0,
                        input bit sx = 0, input bit se = 0, input bit fs = 0);
      op_kind = 4'(k); in_cmd = 2'(cmd); in_order = 8'(ord); in_simple_fwd = sf;
      snp_excl = sx; snp_express = se; fill_shared = fs; op_valid = 1'b1;
      #2;
      r_hit = int'(snp_hit); r_inh = int'(snp_inhibit); r_sup = int'(snp_supply_excl);
      r_shr = int'(snp_shared); r_fsh = int'(fill_shared_out); r_ret = int'(retired);
      r_pv = int'(pop_valid); r_pcmd = int'(pop_cmd); r_pcpu = int'(pop_cpu);
      r_pmark = int'(pop_mark); r_pord = int'(pop_order);
      @(posedge clk); @(negedge clk);
      op_valid = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 reset valid", int'(entry_valid), 0);
      chk("R1 reset in_service", int'(in_service), 0);
      chk("R11 reset prim_cnt", int'(prim_cnt), 0);
      chk("R12 reset proto_err", int'(proto_err), 0);
   endtask

   task automatic t_defer();
      do_op(K_ALLOC, C_RD, 5);
      chk("R1 valid", int'(entry_valid), 1);
      chk("R1 order", int'(entry_order), 5);
      chk("R1 addr", int'(entry_addr), 32'h1000);
      chk("R1 prim_cnt", int'(prim_cnt), 1);
      do_op(K_ADD, C_RD, 6);
      chk("R3 idle add to primary", int'(prim_cnt), 2);
      do_op(K_SVC);
      chk("R10 in service", int'(in_service), 1);
      do_op(K_ADD, C_RX, 7);
      chk("R3 excl behind read deferred", int'(def_cnt), 1);
      do_op(K_ADD, C_RD, 8);
      chk("R3 follower deferred", int'(def_cnt), 2);
      do_op(K_SNP, 0, 20);
      chk("R7 hit", r_hit, 1);
      chk("R7 shared", r_shr, 1);
      chk("R7 no inhibit", r_inh, 0);
      chk("R7 pend_shared", int'(pend_shared), 1);
      chk("R7 no record", int'(prim_cnt), 2);
      do_op(K_FILL, 0, 0, 0, 0, 0, 0);
      chk("R8 shared by pending", r_fsh, 1);
      chk("R8 no merge when shared", int'(def_cnt), 2);
      do_op(K_POP);
      chk("R13 pop valid", r_pv, 1);
      chk("R13 pop order", r_pord, 5);
      chk("R13 pop cpu", r_pcpu, 1);
      chk("R10 mark cleared", r_pmark, 0);
      do_op(K_POP);
      chk("R13 pop order 2", r_pord, 6);
      do_op(K_PROM);
      chk("R9 prim_cnt", int'(prim_cnt), 2);
      chk("R9 def_cnt", int'(def_cnt), 0);
      chk("R9 pend_shared", int'(pend_shared), 0);
      chk("R9 order", int'(entry_order), 7);
      chk("R9 need_excl", int'(need_excl), 1);
      chk("R9 in_service", int'(in_service), 0);
      do_op(K_POP);
      chk("R9 head order", r_pord, 7);
      chk("R9 mark kept", r_pmark, 1);
      do_op(K_POP);
      do_op(K_DEAL);
      chk("R12 dealloc", int'(entry_valid), 0);
      chk("R12 no err", int'(proto_err), 0);
   endtask

   task automatic t_merge();
      do_op(K_ALLOC, C_RD, 1);
      do_op(K_SVC);
      do_op(K_ADD, C_RX, 2);
      chk("R3 deferred", int'(def_cnt), 1);
      do_op(K_FILL, 0, 0, 0, 0, 0, 1);
      chk("R8 shared pass", r_fsh, 1);
      chk("R8 shared fill keeps deferred", int'(def_cnt), 1);
      do_op(K_FILL);
      chk("R8 excl fill", r_fsh, 0);
      chk("R8 merged prim", int'(prim_cnt), 2);
      chk("R8 merged def", int'(def_cnt), 0);
      chk("R8 need_excl", int'(need_excl), 1);
      do_op(K_POP);
      chk("R8 order 1", r_pord, 1);
      do_op(K_POP);
      chk("R8 tail order", r_pord, 2);
      chk("R8 tail mark", r_pmark, 0);
      chk("R8 tail cmd", r_pcmd, C_RX);
      do_op(K_DEAL);
      chk("R12 no err", int'(proto_err), 0);
   endtask

   task automatic t_snoop();
      do_op(K_ALLOC, C_UP, 1);
      chk("R2 need_excl", int'(need_excl), 1);
      chk("R2 upg", int'(upg_pending), 1);
      do_op(K_SVC);
      do_op(K_SNP, 0, 9);
      chk("R6 inhibit", r_inh, 1);
      chk("R6 supply", r_sup, 1);
      chk("R6 no shared", r_shr, 0);
      chk("R6 recorded", int'(prim_cnt), 2);
      chk("R6 no inval", int'(pend_inval), 0);
      do_op(K_SNP, 0, 10, 0, 1);
      chk("R6 excl inhibit", r_inh, 1);
      chk("R6 pend_inval", int'(pend_inval), 1);
      chk("R6 recorded 2", int'(prim_cnt), 3);
      do_op(K_ADD, C_RD, 3);
      do_op(K_ADD, C_UP, 4);
      chk("R3 inval defers", int'(def_cnt), 2);
      do_op(K_SNP, 0, 11, 0, 1);
      chk("R5 ack", r_hit, 1);
      chk("R5 no inhibit", r_inh, 0);
      chk("R5 no record", int'(prim_cnt), 3);
      do_op(K_POP);
      chk("R5 primary upgrade kept", r_pcmd, C_UP);
      do_op(K_POP);
      chk("R6 mem target order", r_pord, 9);
      chk("R6 mem target cpu", r_pcpu, 0);
      chk("R6 mem target cmd", r_pcmd, C_RD);
      do_op(K_POP);
      chk("R6 excl target cmd", r_pcmd, C_RX);
      do_op(K_PROM);
      chk("R9 inval cleared", int'(pend_inval), 0);
      chk("R9 order 3", int'(entry_order), 3);
      do_op(K_POP);
      do_op(K_POP);
      chk("R5 deferred upgrade rewritten", r_pcmd, C_RX);
      do_op(K_DEAL);
      chk("R12 no err", int'(proto_err), 0);
   endtask

   task automatic t_idle_snoop();
      do_op(K_ALLOC, C_UP, 1);
      do_op(K_ADD, C_UP, 2);
      do_op(K_SNP, 0, 30, 0, 1);
      chk("R4 idle no hit", r_hit, 0);
      chk("R4 idle no inhibit", r_inh, 0);
      chk("R4 idle no record", int'(prim_cnt), 2);
      chk("R4 upg cleared", int'(upg_pending), 0);
      do_op(K_POP);
      chk("R4 rewrite 1", r_pcmd, C_RX);
      do_op(K_POP);
      chk("R4 rewrite 2", r_pcmd, C_RX);
      do_op(K_DEAL);
      do_op(K_ALLOC, C_RD, 1);
      do_op(K_DSET);
      chk("R10 dn set", int'(dn_pending), 1);
      do_op(K_SVC);
      do_op(K_SNP, 0, 31, 0, 0, 1);
      chk("R4 express no hit", r_hit, 0);
      chk("R4 express no shared", r_shr, 0);
      chk("R4 express pend_shared", int'(pend_shared), 0);
      do_op(K_POP);
      chk("R10 marks kept while downstream pending", r_pmark, 1);
      do_op(K_DEAL);
      chk("R12 no err", int'(proto_err), 0);
   endtask

   task automatic t_sfwd();
      do_op(K_ALLOC, C_RD, 1, 1);
      do_op(K_SVC);
      chk("R10 retired", r_ret, 1);
      chk("R10 popped", r_pv, 1);
      chk("R10 popped order", r_pord, 1);
      chk("R10 empty", int'(prim_cnt), 0);
      chk("R10 not in service", int'(in_service), 0);
      do_op(K_DEAL);
      chk("R12 dealloc", int'(entry_valid), 0);
      chk("R12 no err", int'(proto_err), 0);
   endtask

   task automatic t_full();
      do_op(K_ALLOC, C_RD, 0);
      for (int i = 1; i < 8; i++) do_op(K_ADD, C_RD, i);
      chk("R11 full", int'(prim_full), 1);
      chk("R11 cnt 8", int'(prim_cnt), 8);
      chk("R11 no err yet", int'(proto_err), 0);
      do_op(K_ADD, C_RD, 8);
      chk("R11 overflow error", int'(proto_err), 1);
      chk("R11 cnt held", int'(prim_cnt), 8);
      do_op(K_DEAL);
      chk("R12 early dealloc refused", int'(entry_valid), 1);
      chk("R12 sticky", int'(proto_err), 1);
   endtask

   initial begin
      #(8 * 150000);
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_defer();
      t_merge();
      t_snoop();
      t_idle_snoop();
      t_sfwd();
      t_full();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule